// File: doc/BRIEF.md
# SPI Byte-Memory Command Controller

This block is a serial-bus slave that fronts a 512-byte memory held inside the chip. A host selects the block with an active-low chip select, clocks 8-bit commands and addresses in on SI with SCK (clock modes 0 and 3), and reads data back on SO. Commands arm or disarm a write-enable latch, read or update a control/status byte, stream the array out sequentially, or program up to one 16-byte page at a time. Stored bytes are protected at three levels: the write-enable latch, a write-protect input pin, and a two-bit lock field that fences off the upper quarter, upper half or all of the array.

All pins are sampled into the system clock domain and the serial clock edges are found by oversampling. An accepted write is held in a page buffer and applied during a timed busy window whose length is a parameter. During that window the busy flag reads as 1 and the status command keeps working. The two watchdog-period bits of the status byte are driven out for a neighbouring timer block.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset the status byte reads 0x30 (layout from bit 7 down: 0, 0, WD1, WD0, BL1, BL0, WEL, WIP), wd_period is 2'b11 and so_oe is 0 while cs_n is high.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1), but only once cs_n has risen after that opcode. Opcode 0x04 clears it.
- R3: A write opcode (0x01 status write, or array write) is ignored unless the latch was armed in an earlier cs_n frame. A latch-arming opcode followed by a write in the same frame does not change memory.
- R4: While wp_n is low the latch is held clear. If wp_n goes low while cs_n is still low in a write frame, that write is dropped.
- R5: Array write has opcode 0000_A010 and array read has 0000_A011, where bit 3 (A) is address bit 8 and the next byte gives address bits 7:0. All bits travel MSB first.
- R6: An array read keeps returning bytes at ascending addresses while SCK runs, wrapping from 0x1FF to 0x000.
- R7: A page write takes any number of bytes. The low 4 address bits wrap inside the 16-byte page, so later bytes overwrite earlier ones.
- R8: A write (array or status) is committed only if cs_n rises with a whole number of data bytes clocked in. A rise in the middle of a byte discards the whole write.
- R9: A committed write clears the latch and holds WIP (status bit 0) at 1 for WR_CYC system clocks. The status read still works in that time, and every write command sent while WIP is 1 is rejected.
- R10: Lock field BL (status bits 3:2) blocks writes: 00 none, 01 addresses 0x180-0x1FF, 10 addresses 0x100-0x1FF, 11 the whole array. Locked bytes still read normally.
- R11: A status write (opcode 0x01, one data byte) updates only bits 5:2. Bits 7:6 read 0, WEL and WIP are not writable, and wd_period follows bits 5:4.
- R12: SO is enabled only while cs_n is low. It changes only after falling SCK edges, and a status read (opcode 0x05) returns the status byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset (power-up state) |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in, sampled on rising SCK |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out, updated after falling SCK |
| so_oe | output | 1 | Output enable for SO (tristate control) |
| wd_period | output | 2 | Watchdog period select bits from the status byte |

## Verification
The hardest case to reach is a status read or a rejected write that lands inside the busy window of an earlier commit. The bench makes this happen by setting a short busy length and starting the next frames right after the committing cs_n rise, so they fall inside the window. The second hard case is a cs_n rise in the middle of a byte. A bit-granular transfer task stops clocking after four bits, and the target byte is read back afterwards to show that it is unchanged.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OP_ARM    = 8'h06;
  localparam logic [7:0] OP_DISARM = 8'h04;
  localparam logic [7:0] OP_STRD   = 8'h05;
  localparam logic [7:0] OP_STWR   = 8'h01;
  localparam logic [2:0] OP_RD_LO  = 3'b011;
  localparam logic [2:0] OP_WR_LO  = 3'b010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_WDATA,
    PH_SRDATA,
    PH_STAT,
    PH_RD,
    PH_SKIP
  } phase_e;

  // Lock decision from the two top address bits and the lock field.
  function automatic logic lock_hit(input logic [1:0] top, input logic [1:0] bl);
    case (bl)
      2'b00:   lock_hit = 1'b0;
      2'b01:   lock_hit = (top == 2'b11);
      2'b10:   lock_hit = top[1];
      default: lock_hit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_ee_ram.sv
module spi_ee_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
  parameter int CYCLES = 2_000_000,
  parameter int SLOTS  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic                     busy,
  output logic [$clog2(SLOTS)-1:0] slot,
  output logic                     slot_ok,
  output logic                     done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam int SW = $clog2(SLOTS);
  logic [CW-1:0] cnt;

  assign done    = busy && (cnt == CW'(CYCLES - 1));
  assign slot    = cnt[SW-1:0];
  assign slot_ok = busy && (cnt < CW'(SLOTS));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy || (CYCLES == 1));
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_ee_pkg::*;
#(
  parameter int AW          = 9,
  parameter int PAGE_AW     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WR_CYC      = 2_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       wp_n,
  output logic       so,
  output logic       so_oe,
  output logic [1:0] wd_period
);
  localparam int PAGE = 1 << PAGE_AW;
  localparam int PW   = AW - PAGE_AW;

  // pin synchronisation: {wp, si, sck, cs}
  logic [3:0] pins_s;
  spi_ee_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst), .d({wp_n, si, sck, cs_n}), .q(pins_s)
  );
  logic cs_s, sck_s, si_s, wp_s;
  assign cs_s  = pins_s[0];
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[2];
  assign wp_s  = pins_s[3];

  logic sck_d, cs_d;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_d & ~cs_s;
  assign sck_fall = ~sck_s & sck_d & ~cs_s;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;

  // control state
  phase_e         ph;
  logic [2:0]     bit_cnt;
  logic [7:0]     in_sh;
  logic [7:0]     out_sh;
  logic           so_q, oe_q;
  logic           a8, opc_wr;
  logic [AW-1:0]  addr;
  logic [AW-1:0]  rd_ptr;
  logic           fetch_go, load_pend;
  logic [7:0]     pbuf [PAGE];
  logic [PAGE-1:0] pvalid;
  logic           wr_any;
  logic [7:0]     sr_new;
  logic           sr_got;
  logic           wel, wel_arm;
  logic [1:0]     st_wd, st_bl;

  // timer and memory
  logic               busy, slot_ok, tmr_done;
  logic [PAGE_AW-1:0] slot;
  logic               mem_we;
  logic [AW-1:0]      mem_addr;
  logic [7:0]         mem_rdata;

  logic [7:0] byte_in, status_w;
  logic       byte_done, commit_w, commit_sr;

  assign byte_in   = {in_sh[6:0], si_s};
  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign status_w  = {2'b00, st_wd, st_bl, wel, busy};
  assign commit_w  = cs_rise && (ph == PH_WDATA) && wr_any && (bit_cnt == 3'd0)
                     && wel && wp_s && !busy;
  assign commit_sr = cs_rise && sr_got && (bit_cnt == 3'd0) && wel && wp_s && !busy;

  spi_ee_wtimer #(.CYCLES(WR_CYC), .SLOTS(PAGE)) u_tmr (
    .clk(clk), .rst(rst), .start(commit_w | commit_sr),
    .busy(busy), .slot(slot), .slot_ok(slot_ok), .done(tmr_done)
  );

  assign mem_we   = slot_ok && pvalid[slot];
  assign mem_addr = mem_we ? {addr[AW-1:PAGE_AW], slot} : rd_ptr;

  spi_ee_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(mem_we), .re(fetch_go), .addr(mem_addr),
    .wdata(pbuf[slot]), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d     <= 1'b0;
      cs_d      <= 1'b1;
      ph        <= PH_IDLE;
      bit_cnt   <= '0;
      in_sh     <= '0;
      out_sh    <= '0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
      a8        <= 1'b0;
      opc_wr    <= 1'b0;
      addr      <= '0;
      rd_ptr    <= '0;
      fetch_go  <= 1'b0;
      load_pend <= 1'b0;
      pvalid    <= '0;
      wr_any    <= 1'b0;
      sr_new    <= '0;
      sr_got    <= 1'b0;
      wel       <= 1'b0;
      wel_arm   <= 1'b0;
      st_wd     <= 2'b11;
      st_bl     <= 2'b00;
    end else begin
      sck_d     <= sck_s;
      cs_d      <= cs_s;
      oe_q      <= ~cs_s;
      fetch_go  <= 1'b0;
      load_pend <= fetch_go;

      if (fetch_go) rd_ptr <= rd_ptr + 1'b1;
      if (load_pend) out_sh <= mem_rdata;
      if (tmr_done) pvalid <= '0;

      if (cs_fall) begin
        ph      <= PH_OPC;
        bit_cnt <= '0;
        so_q    <= 1'b0;
        wr_any  <= 1'b0;
        sr_got  <= 1'b0;
        wel_arm <= 1'b0;
      end

      if (sck_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        in_sh   <= byte_in;
      end

      if (byte_done) begin
        case (ph)
          PH_OPC: begin
            if (byte_in == OP_ARM) begin
              wel_arm <= 1'b1;
              ph      <= PH_SKIP;
            end else if (byte_in == OP_DISARM) begin
              wel     <= 1'b0;
              wel_arm <= 1'b0;
              ph      <= PH_SKIP;
            end else if (byte_in == OP_STRD) begin
              out_sh <= status_w;
              ph     <= PH_STAT;
            end else if (byte_in == OP_STWR) begin
              ph <= (wel && !busy) ? PH_SRDATA : PH_SKIP;
            end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == OP_RD_LO) begin
              a8     <= byte_in[3];
              opc_wr <= 1'b0;
              ph     <= busy ? PH_SKIP : PH_ADDR;
            end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == OP_WR_LO) begin
              a8     <= byte_in[3];
              opc_wr <= 1'b1;
              ph     <= (wel && !busy) ? PH_ADDR : PH_SKIP;
            end else begin
              ph <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            addr <= {a8, byte_in};
            if (opc_wr) begin
              ph     <= PH_WDATA;
              pvalid <= '0;
            end else begin
              ph       <= PH_RD;
              rd_ptr   <= {a8, byte_in};
              fetch_go <= 1'b1;
            end
          end
          PH_WDATA: begin
            pbuf[addr[PAGE_AW-1:0]] <= byte_in;
            if (!lock_hit(addr[AW-1:AW-2], st_bl))
              pvalid[addr[PAGE_AW-1:0]] <= 1'b1;
            addr[PAGE_AW-1:0] <= addr[PAGE_AW-1:0] + 1'b1;
            wr_any <= 1'b1;
          end
          PH_SRDATA: begin
            sr_new <= byte_in;
            sr_got <= 1'b1;
            ph     <= PH_SKIP;
          end
          PH_STAT: out_sh <= status_w;
          PH_RD:   fetch_go <= 1'b1;
          default: ;
        endcase
      end

      if (sck_fall) begin
        if (ph == PH_STAT || ph == PH_RD) begin
          so_q   <= out_sh[7];
          out_sh <= {out_sh[6:0], 1'b0};
        end else begin
          so_q <= 1'b0;
        end
      end

      if (cs_rise) begin
        ph <= PH_IDLE;
        if (wel_arm && wp_s) wel <= 1'b1;
        wel_arm <= 1'b0;
        if (commit_w || commit_sr) wel <= 1'b0;
        if (commit_sr) begin
          st_wd <= sr_new[5:4];
          st_bl <= sr_new[3:2];
        end
        if (!commit_w && !busy) pvalid <= '0;
      end

      if (!wp_s) begin
        wel     <= 1'b0;
        wel_arm <= 1'b0;
      end
    end
  end

  assign so        = so_q;
  assign so_oe     = oe_q;
  assign wd_period = st_wd;

  p_wel_wp_r4: assert property (@(posedge clk) disable iff (rst)
    !wp_s |=> !wel);
  p_we_unlocked_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !lock_hit(mem_addr[AW-1:AW-2], st_bl));
  p_we_busy_r9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  p_wip_clears_wel_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !wel);
  p_wd_on_csrise_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(st_wd) |-> $past(cs_rise));
  p_oe_deselect_r12: assert property (@(posedge clk) disable iff (rst)
    $past(cs_s) |-> !so_oe);
endmodule

// File: tb/spi_eeprom_ctrl_tb.sv
module spi_eeprom_ctrl_tb;
  localparam int HP     = 8;
  localparam int WRC    = 1500;
  localparam int NVEC   = 10;
  // {addr[8:0], data[7:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    17'h00011, 17'h07F22, 17'h08033, 17'h0FF44, 17'h10055,
    17'h17F66, 17'h18077, 17'h1FE88, 17'h1FF99, 17'h001AA
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe;
  logic [1:0] wd_period;

  int checks = 0;
  int fails  = 0;
  int hold_err = 0;
  logic [7:0] rbuf [20];
  logic [7:0] st;

  always #2.5 clk = ~clk;

  spi_eeprom_ctrl #(.WR_CYC(WRC)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so(so), .so_oe(so_oe), .wd_period(wd_period)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = tx[i];
      repeat (HP) @(negedge clk);
      rx[i] = so;
      sck = 1'b1;
      repeat (HP - 1) @(negedge clk);
      if (so_oe && (so !== rx[i])) hold_err++;
      @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HP) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xfer(op, 8, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, 8, d); xfer(8'h00, 8, v); cs_hi();
  endtask

  task automatic wait_idle();
    repeat (WRC + 40) @(negedge clk);
  endtask

  task automatic wr_seq(input logic [8:0] a, input int n, input logic [7:0] first);
    logic [7:0] d;
    cs_lo();
    xfer({4'h0, a[8], 3'b010}, 8, d);
    xfer(a[7:0], 8, d);
    for (int i = 0; i < n; i++) xfer(first + 8'(i), 8, d);
    cs_hi();
  endtask

  task automatic wr_full(input logic [8:0] a, input logic [7:0] v);
    cmd1(8'h06);
    wr_seq(a, 1, v);
    wait_idle();
  endtask

  task automatic rd_seq(input logic [8:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    xfer({4'h0, a[8], 3'b011}, 8, d);
    xfer(a[7:0], 8, d);
    for (int i = 0; i < n; i++) xfer(8'h00, 8, rbuf[i]);
    cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cmd1(8'h06);
    cs_lo(); xfer(8'h01, 8, d); xfer(v, 8, d); cs_hi();
    wait_idle();
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R1 reset state
    chk(so_oe == 1'b0, "R1 so_oe idle", 32'(so_oe), 0);
    chk(wd_period == 2'b11, "R1 wd_period", 32'(wd_period), 3);
    rdsr(st);
    chk(st == 8'h30, "R1 status default", 32'(st), 32'h30);

    // R12 output enable during a frame
    cs_lo();
    repeat (4) @(negedge clk);
    chk(so_oe == 1'b1, "R12 so_oe in frame", 32'(so_oe), 1);
    cs_hi();
    chk(so_oe == 1'b0, "R12 so_oe after frame", 32'(so_oe), 0);

    // R2 latch arm / disarm
    cmd1(8'h06);
    rdsr(st);
    chk(st == 8'h32, "R2 WEL set", 32'(st), 32'h32);
    cmd1(8'h04);
    rdsr(st);
    chk(st == 8'h30, "R2 WEL cleared", 32'(st), 32'h30);

    // R5 table walk: write every vector, then read back
    for (int k = 0; k < NVEC; k++) wr_full(VEC[k][16:8], VEC[k][7:0]);
    for (int k = 0; k < NVEC; k++) begin
      rd_seq(VEC[k][16:8], 1);
      chk(rbuf[0] == VEC[k][7:0], "R5 table readback", 32'(rbuf[0]), 32'(VEC[k][7:0]));
    end

    // R6 sequential read wrap 0x1FE -> 0x001
    rd_seq(9'h1FE, 4);
    chk(rbuf[0] == 8'h88 && rbuf[1] == 8'h99, "R6 ascending", {rbuf[0], rbuf[1]}, 32'h8899);
    chk(rbuf[2] == 8'h11 && rbuf[3] == 8'hAA, "R6 wrap to 0", {rbuf[2], rbuf[3]}, 32'h11AA);

    // R3 write without arming, and arming in the same frame
    wr_seq(9'h080, 1, 8'h5A);
    wait_idle();
    rd_seq(9'h080, 1);
    chk(rbuf[0] == 8'h33, "R3 unarmed write ignored", 32'(rbuf[0]), 32'h33);
    cs_lo(); xfer(8'h06, 8, d); xfer(8'h02, 8, d); xfer(8'h80, 8, d); xfer(8'h5B, 8, d); cs_hi();
    wait_idle();
    rd_seq(9'h080, 1);
    chk(rbuf[0] == 8'h33, "R3 same-frame arm ignored", 32'(rbuf[0]), 32'h33);
    cmd1(8'h04);

    // R4 WP low clears latch; WP drop inside write frame cancels
    cmd1(8'h06);
    wp_n = 1'b0; repeat (10) @(negedge clk); wp_n = 1'b1;
    rdsr(st);
    chk(st[1] == 1'b0, "R4 WEL cleared by wp", 32'(st), 32'h30);
    cmd1(8'h06);
    cs_lo(); xfer(8'h02, 8, d); xfer(8'h7F, 8, d); xfer(8'hC4, 8, d);
    wp_n = 1'b0;
    cs_hi();
    wp_n = 1'b1;
    rdsr(st);
    chk(st == 8'h30, "R4 no busy after wp cancel", 32'(st), 32'h30);
    rd_seq(9'h07F, 1);
    chk(rbuf[0] == 8'h22, "R4 data kept", 32'(rbuf[0]), 32'h22);

    // R8 abort on mid-byte cs rise
    cmd1(8'h06);
    cs_lo(); xfer(8'h02, 8, d); xfer(8'hFF, 8, d); xfer(8'hC5, 4, d); cs_hi();
    wait_idle();
    rd_seq(9'h0FF, 1);
    chk(rbuf[0] == 8'h44, "R8 aborted write", 32'(rbuf[0]), 32'h44);
    cmd1(8'h04);

    // R7 page wrap: 17 bytes from 0x060
    cmd1(8'h06);
    wr_seq(9'h060, 17, 8'hA0);
    // R9 busy window
    rdsr(st);
    chk(st == 8'h31, "R9 WIP set and WEL cleared", 32'(st), 32'h31);
    cmd1(8'h06);
    wr_seq(9'h0FF, 1, 8'hC6);
    wait_idle();
    rdsr(st);
    chk(st == 8'h32, "R9 WIP done, WEL from armed cmd", 32'(st), 32'h32);
    cmd1(8'h04);
    rd_seq(9'h0FF, 1);
    chk(rbuf[0] == 8'h44, "R9 write during busy rejected", 32'(rbuf[0]), 32'h44);
    rd_seq(9'h060, 16);
    chk(rbuf[0] == 8'hB0, "R7 wrapped overwrite", 32'(rbuf[0]), 32'hB0);
    chk(rbuf[1] == 8'hA1 && rbuf[15] == 8'hAF, "R7 page body", {rbuf[1], rbuf[15]}, 32'hA1AF);

    // R10 lock codes
    wrsr(8'h34);
    wr_full(9'h180, 8'hE1);
    wr_full(9'h100, 8'hE2);
    rd_seq(9'h180, 1);
    chk(rbuf[0] == 8'h77, "R10 BL01 locks 0x180", 32'(rbuf[0]), 32'h77);
    rd_seq(9'h100, 1);
    chk(rbuf[0] == 8'hE2, "R10 BL01 leaves 0x100", 32'(rbuf[0]), 32'hE2);
    wrsr(8'h38);
    wr_full(9'h100, 8'hE3);
    wr_full(9'h0FF, 8'hE4);
    rd_seq(9'h100, 1);
    chk(rbuf[0] == 8'hE2, "R10 BL10 locks 0x100", 32'(rbuf[0]), 32'hE2);
    rd_seq(9'h0FF, 1);
    chk(rbuf[0] == 8'hE4, "R10 BL10 leaves 0x0FF", 32'(rbuf[0]), 32'hE4);
    wrsr(8'h3C);
    wr_full(9'h000, 8'hE5);
    rd_seq(9'h000, 1);
    chk(rbuf[0] == 8'h11, "R10 BL11 locks all, read ok", 32'(rbuf[0]), 32'h11);

    // R11 status write field masking
    rdsr(st);
    chk(st == 8'h3C, "R11 status after lock", 32'(st), 32'h3C);
    wrsr(8'hDB);
    rdsr(st);
    chk(st == 8'h18, "R11 masked status write", 32'(st), 32'h18);
    chk(wd_period == 2'b01, "R11 wd_period follows", 32'(wd_period), 1);
    wrsr(8'h30);
    chk(wd_period == 2'b11, "R11 wd_period restored", 32'(wd_period), 3);

    // R12 SO stable while SCK high
    chk(hold_err == 0, "R12 SO changes only after fall", hold_err, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule